// File: doc/BRIEF.md
# USB suspend and resume controller

This block manages low-power entry and exit for a USB device built around an embedded CPU. It runs from an always-on low-frequency reference clock, so it keeps working while the main oscillator is stopped. When the bus has carried no traffic for 3 ms, it raises a suspend interrupt. The clocks stay running at that point. The CPU shuts down its peripherals and then sets its power-down bit. Only then does the block drop the oscillator/PLL enable and gate the CPU clock.

Two sources can wake the block: renewed bus traffic, or a low level on the remote-wakeup pin. Both run the same sequence. The block turns the oscillator back on and counts a fixed number of reference cycles so the clocks can settle. It then releases the CPU clock, clears the power-down bit and raises a high-priority resume interrupt. The CPU therefore carries on from the instruction after the one that set the power-down bit. A wake event that arrives after the suspend interrupt, but before the power-down bit is set, cancels the pending suspend and never stops the clocks.

Top module: `usb_suspend_ctl`

## Requirements
- R1: After reset, `osc_en` and `cpu_clk_en` are 1, and `susp_irq`, `res_irq`, `pd_bit` and `remote_wake` are 0.
- R2: `susp_irq` rises once `IDLE_CYC` consecutive synchronised cycles of low `bus_act` have been counted (IDLE_CYC = CLK_HZ*IDLE_US/1e6). That is `IDLE_CYC`+2 edges after `bus_act` falls. Any high cycle restarts the count.
- R3: While a suspend is pending and `pd_set` has not been pulsed, `osc_en` and `cpu_clk_en` stay at 1.
- R4: A `pd_set` pulse while a suspend is pending makes `osc_en`=0, `cpu_clk_en`=0 and `pd_bit`=1 on the next edge. These values hold until a wake event.
- R5: A `pd_set` pulse while no suspend is pending is ignored: `pd_bit` stays 0, and `osc_en` and `cpu_clk_en` stay 1.
- R6: A wake event during a pending suspend cancels it. A later `pd_set` is then ignored until a fresh idle timeout has occurred.
- R7: While suspended, `bus_act`=1 or `wake_n`=0 sets `osc_en` to 1 three edges after the input changes, once it has passed the two-flop synchroniser. `remote_wake` is set at the same edge when the pin caused the wake.
- R8: `SETTLE_CYC` edges after `osc_en` rises, `res_irq` and `cpu_clk_en` rise and `pd_bit` clears, all on the same edge. `cpu_clk_en` stays 0 and `pd_bit` stays 1 before that edge.
- R9: Each interrupt request holds until a one-cycle clear (`susp_clr` or `res_clr`), and falls on the edge after that clear. `res_clr` also clears `remote_wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_act | input | 1 | Bus activity indication, asynchronous |
| wake_n | input | 1 | Remote-wakeup pin, active low, asynchronous |
| pd_set | input | 1 | One-cycle pulse: the CPU sets its power-down bit |
| susp_clr | input | 1 | One-cycle acknowledge of the suspend interrupt |
| res_clr | input | 1 | One-cycle acknowledge of the resume interrupt |
| susp_irq | output | 1 | Suspend interrupt request |
| res_irq | output | 1 | High-priority resume interrupt request |
| osc_en | output | 1 | Oscillator and PLL enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| pd_bit | output | 1 | Current value of the power-down bit |
| remote_wake | output | 1 | Wake was requested by the pin |

## Verification
Faults in the state register or the shared counter appear on the clock-control outputs. An idle count that is off by one moves the rise of `susp_irq` by one edge. A wrong reset value of the counter when the wake sequence starts moves the joint rise of `res_irq` and `cpu_clk_en` away from `osc_en`+`SETTLE_CYC`. A missed cancel shows up on the very next edge after a stray `pd_set`, as a dropped `osc_en`. The bench checks every transition at its exact edge, so a single-cycle shift is reported.

// File: rtl/usb_suspend_ctl.sv
module usb_suspend_ctl #(
  parameter int CLK_HZ     = 32768,
  parameter int IDLE_US    = 3000,
  parameter int SETTLE_CYC = 16
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic bus_act,
  input  logic wake_n,
  input  logic pd_set,
  input  logic susp_clr,
  input  logic res_clr,
  output logic susp_irq,
  output logic res_irq,
  output logic osc_en,
  output logic cpu_clk_en,
  output logic pd_bit,
  output logic remote_wake
);
  localparam int IDLE_CYC = int'((64'(CLK_HZ) * 64'(IDLE_US)) / 64'd1000000);
  localparam int CMAX     = (IDLE_CYC > SETTLE_CYC) ? IDLE_CYC : SETTLE_CYC;
  localparam int CW       = $clog2(CMAX + 1);

  typedef enum logic [2:0] {ACTIVE, SUSPEND_PENDING, SUSPENDED, WAKING, RESUME_IRQ} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    act_q, wk_q;
  logic          act_s, wk_s, wake_evt;

  assign act_s    = act_q[1];
  assign wk_s     = wk_q[1];
  assign wake_evt = act_s | wk_s;

  assign osc_en     = (st != SUSPENDED);
  assign cpu_clk_en = (st == ACTIVE) || (st == SUSPEND_PENDING) || (st == RESUME_IRQ);
  assign pd_bit     = (st == SUSPENDED) || (st == WAKING);
  assign res_irq    = (st == RESUME_IRQ);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ACTIVE;
      cnt         <= '0;
      act_q       <= '0;
      wk_q        <= '0;
      susp_irq    <= 1'b0;
      remote_wake <= 1'b0;
    end else begin
      act_q <= {act_q[0], bus_act};
      wk_q  <= {wk_q[0], ~wake_n};
      if (susp_clr) susp_irq <= 1'b0;
      case (st)
        ACTIVE: begin
          if (act_s) cnt <= '0;
          else if (cnt == CW'(IDLE_CYC - 1)) begin
            st       <= SUSPEND_PENDING;
            susp_irq <= 1'b1;
            cnt      <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SUSPEND_PENDING: begin
          if (wake_evt) st <= ACTIVE;
          else if (pd_set) st <= SUSPENDED;
        end
        SUSPENDED: begin
          if (wake_evt) begin
            st          <= WAKING;
            cnt         <= '0;
            remote_wake <= wk_s;
          end
        end
        WAKING: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            st  <= RESUME_IRQ;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        RESUME_IRQ: begin
          if (res_clr) begin
            st          <= ACTIVE;
            remote_wake <= 1'b0;
          end
        end
        default: st <= ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/usb_suspend_ctl_chk.sv
module usb_suspend_ctl_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic pd_set,
  input logic susp_clr,
  input logic res_clr,
  input logic susp_irq,
  input logic res_irq,
  input logic osc_en,
  input logic cpu_clk_en,
  input logic pd_bit
);
  a_r4_gate_needs_pd: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(osc_en) |-> $past(pd_set));

  a_r8_cpu_off_while_pd: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pd_bit |-> !cpu_clk_en);

  a_r8_res_after_osc: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(res_irq) |-> ($past(osc_en) && !pd_bit && cpu_clk_en));

  a_r9_susp_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (susp_irq && !susp_clr) |=> susp_irq);

  a_r9_res_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (res_irq && !res_clr) |=> res_irq);
endmodule

bind usb_suspend_ctl usb_suspend_ctl_chk u_chk (.*);

// File: tb/usb_suspend_ctl_tb.sv
module usb_suspend_ctl_tb;
  localparam int IDLE = 98;
  localparam int S    = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_act = 1'b1, wake_n = 1'b1, pd_set = 1'b0, susp_clr = 1'b0, res_clr = 1'b0;
  logic susp_irq, res_irq, osc_en, cpu_clk_en, pd_bit, remote_wake;

  usb_suspend_ctl u_dut (
    .clk_ref(clk), .rst_n(rst_n), .bus_act(bus_act), .wake_n(wake_n), .pd_set(pd_set),
    .susp_clr(susp_clr), .res_clr(res_clr), .susp_irq(susp_irq), .res_irq(res_irq),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .pd_bit(pd_bit), .remote_wake(remote_wake));

  always #2 clk = ~clk;

  typedef struct { int at; logic [5:0] v; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, runs = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bit order {susp_irq, res_irq, osc_en, cpu_clk_en, pd_bit, remote_wake}
  task automatic expect_at(input int at, input logic [5:0] v, input string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  always @(negedge clk) begin
    logic [5:0] got;
    got = {susp_irq, res_irq, osc_en, cpu_clk_en, pd_bit, remote_wake};
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      runs++;
      if (e.at != cyc || got !== e.v) begin
        fails++;
        $display("FAIL %s cyc %0d: got %b expected %b (due %0d)", e.tag, cyc, got, e.v, e.at);
      end
    end
  end

  task automatic idle_to_suspend(input string tag);
    int t;
    bus_act = 1'b0; t = cyc;
    expect_at(t + IDLE + 1, 6'b001100, tag);
    expect_at(t + IDLE + 2, 6'b101100, tag);
    step(IDLE + 3);
    pulse(susp_clr);
  endtask

  initial begin
    int t, t1;
    step(3); rst_n = 1'b1; step(1);
    expect_at(cyc + 1, 6'b001100, "R1");
    step(2);

    t = cyc; pd_set = 1'b1;                       // R5
    expect_at(t + 1, 6'b001100, "R5");
    expect_at(t + 2, 6'b001100, "R5");
    step(1); pd_set = 1'b0; step(3);

    t = cyc; bus_act = 1'b0; step(IDLE - 10);      // R2 restart
    t1 = cyc; bus_act = 1'b1; step(1); bus_act = 1'b0;
    expect_at(t + IDLE + 2, 6'b001100, "R2");
    expect_at(t1 + IDLE + 2, 6'b001100, "R2");
    expect_at(t1 + IDLE + 3, 6'b101100, "R2");
    step(IDLE + 4);

    expect_at(cyc + 20, 6'b101100, "R3");          // R3 clocks stay on
    step(21);
    t = cyc; susp_clr = 1'b1;
    expect_at(t + 1, 6'b001100, "R9");
    step(1); susp_clr = 1'b0;

    t = cyc; bus_act = 1'b1; step(4);              // R6 cancel
    pd_set = 1'b1;
    expect_at(t + 5, 6'b001100, "R6");
    expect_at(t + 6, 6'b001100, "R6");
    step(1); pd_set = 1'b0; step(2);

    idle_to_suspend("R2");
    t = cyc; pd_set = 1'b1;                        // R4
    expect_at(t + 1, 6'b000010, "R4");
    expect_at(t + 10, 6'b000010, "R4");
    step(1); pd_set = 1'b0; step(10);

    t = cyc; bus_act = 1'b1;                       // R7 bus wake, R8 settle
    expect_at(t + 2, 6'b000010, "R7");
    expect_at(t + 3, 6'b001010, "R7");
    expect_at(t + 2 + S, 6'b001010, "R8");
    expect_at(t + 3 + S, 6'b011100, "R8");
    expect_at(t + 8 + S, 6'b011100, "R9");
    step(9 + S);
    t = cyc; res_clr = 1'b1;
    expect_at(t + 1, 6'b001100, "R9");
    step(1); res_clr = 1'b0; step(2);

    idle_to_suspend("R2");
    pulse(pd_set); step(5);
    t = cyc; wake_n = 1'b0;                        // R7 pin wake
    expect_at(t + 2, 6'b000010, "R7");
    expect_at(t + 3, 6'b001011, "R7");
    expect_at(t + 3 + S, 6'b011101, "R8");
    step(4 + S); wake_n = 1'b1; step(2);
    t = cyc; res_clr = 1'b1;
    expect_at(t + 1, 6'b001100, "R9");
    step(1); res_clr = 1'b0; step(5);

    wait (q.size() == 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule